// File: doc/BRIEF.md
# Block-Buffer DMA Engine

This engine moves whole blocks of card data between the host's data buffer and system memory. It does so without the processor copying each word. Software programs a 64-bit memory address, picks a direction and an addressing style, and then writes a self-clearing start bit. The transfer length in bytes is the host's block size times its block count. The engine moves that length as 32-bit beats over a request/acknowledge memory port. On the buffer side it pops or pushes one word per beat.

When the transfer ends, a per-direction completion flag is set. A start with an address that is not 16-byte aligned sets a per-direction error flag and moves nothing. Both flag words are cleared by writing 0 to a bit, and each has a mask. The interrupt output is high while any unmasked flag is set. A separate enable input, driven by the host's DMA-enable mode bit, gates starts. While that input is low, the buffer belongs to programmed I/O and starts are ignored. Each direction also has a reset bit that aborts a transfer in that direction and clears that direction's flags.

Register offsets (byte address on `reg_addr_i`): mode 0x00, control 0x04, channel reset 0x08, completion status 0x0C, completion mask 0x10, error status 0x14, error mask 0x18, address low word 0x1C, address high word 0x20.

Top module: `sdma_top`

## Requirements
- R1: After reset, the completion and error status words, the masks, the control word read back and `irq_o`, `mem_req_o`, `buf_rd_o` and `buf_wr_o` are all 0.
- R2: With mode bit 16 set (card to memory) and mode bit 0 set, beat i pops one buffer word and writes it to memory at base + 4*i. The base is {address high word, address low word}.
- R3: With mode bit 16 clear (memory to card) and mode bit 0 set, beat i reads memory at base + 4*i and pushes that word to the buffer, in address order.
- R4: A transfer issues exactly (block size × block count) / 4 memory beats. A length of zero completes at once with no memory request.
- R5: With mode bit 0 clear, every beat uses the base address unchanged. Memory above the base is left untouched.
- R6: Writing 1 to control bit 0 starts a transfer. Control bit 0 reads 1 while the transfer runs and returns to 0 by itself when it ends.
- R7: The end of a card-to-memory transfer sets completion bit 20. The end of a memory-to-card transfer sets completion bit 16.
- R8: A start whose address has any of its low 4 bits set issues no memory request and sets no completion flag. It sets error bit 17 for card-to-memory, or error bit 16 for memory-to-card.
- R9: While `dma_en_i` is low, a start is ignored: no request, no status change, and control bit 0 stays 0.
- R10: Writing the completion or error status word clears each defined bit written as 0 and keeps each bit written as 1.
- R11: `irq_o` is high exactly when some status bit is set whose mask bit (same position in the matching mask word) is 0.
- R12: Writing channel-reset bit 9 aborts a running card-to-memory transfer and clears completion bit 20 and error bit 17. Bit 8 does the same for memory-to-card and bits 16/16. The other direction's flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en_i | input | 1 | Host DMA-enable mode bit; low leaves the buffer to programmed I/O |
| blk_size_i | input | SIZE_W | Host block size in bytes |
| blk_cnt_i | input | CNT_W | Host block count |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory beat request, held until acknowledged |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | ADDR_W | Beat byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Beat acknowledge |
| buf_rd_o | output | 1 | Pop one word from the data buffer |
| buf_rdata_i | input | 32 | Buffer head word |
| buf_wr_o | output | 1 | Push one word into the data buffer |
| buf_wdata_o | output | 32 | Word pushed into the buffer |
| irq_o | output | 1 | Interrupt: any unmasked status bit set |

## Verification
Five transfers walk every mix of direction and addressing style. Each one checks the data and also the number of beats, which separates a correct length product from an off-by-one or a truncated count. A zero-length case shows that completion does not need a single beat. A fixed-address card-to-memory run leaves only the last popped word at the base and the next word untouched, which separates a held address from an incrementing one. Misaligned starts in both directions, a start with the enable low, and a channel reset in mid-transfer show that each direction's flags move independently and that an aborted or refused start leaves the memory port silent.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int REG_AW = 6;
    localparam int DW     = 32;

    // register byte offsets
    localparam logic [REG_AW-1:0] OFS_MODE  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h04;
    localparam logic [REG_AW-1:0] OFS_CHRST = 6'h08;
    localparam logic [REG_AW-1:0] OFS_DONE  = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_DMSK  = 6'h10;
    localparam logic [REG_AW-1:0] OFS_ERR   = 6'h14;
    localparam logic [REG_AW-1:0] OFS_EMSK  = 6'h18;
    localparam logic [REG_AW-1:0] OFS_ALO   = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_AHI   = 6'h20;

    // bit positions software decodes
    localparam int B_DIR        = 16;
    localparam int B_INC        = 0;
    localparam int B_GO         = 0;
    localparam int B_RST_RD     = 9;
    localparam int B_RST_WR     = 8;
    localparam int B_FIN_TOMEM  = 20;
    localparam int B_FIN_TOCARD = 16;
    localparam int B_FLT_RD     = 17;
    localparam int B_FLT_WR     = 16;

    // channel vector index: 1 = card-to-memory, 0 = memory-to-card
    localparam int CH_RD = 1;
    localparam int CH_WR = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULL,
        ST_MEM,
        ST_PUSH
    } eng_state_e;

    typedef struct packed {
        logic to_mem;
        logic inc;
    } xfer_mode_t;

    // place a two-channel flag pair into a register word
    function automatic logic [DW-1:0] pack_pair(logic [1:0] v, int pos_rd, int pos_wr);
        logic [DW-1:0] w;
        w = '0;
        w[pos_rd] = v[CH_RD];
        w[pos_wr] = v[CH_WR];
        return w;
    endfunction

    function automatic logic [1:0] pick_pair(logic [DW-1:0] w, int pos_rd, int pos_wr);
        return {w[pos_rd], w[pos_wr]};
    endfunction

endpackage

// File: rtl/sdma_len.sv
module sdma_len
    import sdma_pkg::*;
#(
    parameter int SIZE_W      = 12,
    parameter int CNT_W       = 16,
    parameter int ALIGN_BYTES = 16,
    localparam int LEN_W      = SIZE_W + CNT_W,
    localparam int BEAT_W     = LEN_W - 2,
    localparam int ALIGN_B    = $clog2(ALIGN_BYTES)
) (
    input  logic [SIZE_W-1:0]  blk_size,
    input  logic [CNT_W-1:0]   blk_cnt,
    input  logic [ALIGN_B-1:0] base_low,
    output logic [BEAT_W-1:0]  beats,
    output logic               misaligned
);
    logic [LEN_W-1:0] bytes;

    always_comb begin
        bytes      = LEN_W'(blk_size) * LEN_W'(blk_cnt);
        beats      = bytes[LEN_W-1:2];
        misaligned = |base_low;
    end
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              busy,
    input  logic [1:0]        done_ev,
    input  logic [1:0]        err_ev,
    output xfer_mode_t        mode,
    output logic [ADDR_W-1:0] base_addr,
    output logic              start,
    output logic [1:0]        chan_rst,
    output logic              irq
);
    xfer_mode_t  mode_q;
    logic [31:0] alo_q, ahi_q;
    logic [1:0]  done_q, err_q, dmsk_q, emsk_q;
    logic [1:0]  keep_done, keep_err, done_n, err_n;
    logic [63:0] base_full;

    always_comb begin
        start     = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[B_GO];
        chan_rst  = (reg_wr && (reg_addr == OFS_CHRST)) ?
                    pick_pair(reg_wdata, B_RST_RD, B_RST_WR) : 2'b00;
        keep_done = (reg_wr && (reg_addr == OFS_DONE)) ?
                    pick_pair(reg_wdata, B_FIN_TOMEM, B_FIN_TOCARD) : 2'b11;
        keep_err  = (reg_wr && (reg_addr == OFS_ERR)) ?
                    pick_pair(reg_wdata, B_FLT_RD, B_FLT_WR) : 2'b11;
        done_n    = (done_q & keep_done & ~chan_rst) | done_ev;
        err_n     = (err_q & keep_err & ~chan_rst) | err_ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            alo_q  <= '0;
            ahi_q  <= '0;
            done_q <= '0;
            err_q  <= '0;
            dmsk_q <= '0;
            emsk_q <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    OFS_MODE: mode_q <= '{to_mem: reg_wdata[B_DIR], inc: reg_wdata[B_INC]};
                    OFS_DMSK: dmsk_q <= pick_pair(reg_wdata, B_FIN_TOMEM, B_FIN_TOCARD);
                    OFS_EMSK: emsk_q <= pick_pair(reg_wdata, B_FLT_RD, B_FLT_WR);
                    OFS_ALO:  alo_q  <= reg_wdata;
                    OFS_AHI:  ahi_q  <= reg_wdata;
                    default:  ;
                endcase
            end
            done_q <= done_n;
            err_q  <= err_n;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_MODE: begin
                reg_rdata[B_DIR] = mode_q.to_mem;
                reg_rdata[B_INC] = mode_q.inc;
            end
            OFS_CTRL: reg_rdata[B_GO] = busy;
            OFS_DONE: reg_rdata = pack_pair(done_q, B_FIN_TOMEM, B_FIN_TOCARD);
            OFS_DMSK: reg_rdata = pack_pair(dmsk_q, B_FIN_TOMEM, B_FIN_TOCARD);
            OFS_ERR:  reg_rdata = pack_pair(err_q, B_FLT_RD, B_FLT_WR);
            OFS_EMSK: reg_rdata = pack_pair(emsk_q, B_FLT_RD, B_FLT_WR);
            OFS_ALO:  reg_rdata = alo_q;
            OFS_AHI:  reg_rdata = ahi_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign base_full = {ahi_q, alo_q};
    assign base_addr = base_full[ADDR_W-1:0];
    assign mode      = mode_q;
    assign irq       = (|(done_q & ~dmsk_q)) | (|(err_q & ~emsk_q));
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int BEAT_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start,
    input  xfer_mode_t        mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] beats,
    input  logic              misaligned,
    input  logic [1:0]        abort,
    output logic              busy,
    output logic [1:0]        done_ev,
    output logic [1:0]        err_ev,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ack,
    output logic              buf_rd,
    input  logic [DW-1:0]     buf_rdata,
    output logic              buf_wr,
    output logic [DW-1:0]     buf_wdata
);
    eng_state_e        state_q;
    xfer_mode_t        mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BEAT_W-1:0] left_q;
    logic [DW-1:0]     hold_q;
    logic [1:0]        done_q, err_q;
    logic              beat_fin;
    logic              last_beat;
    logic [ADDR_W-1:0] step;

    always_comb begin
        beat_fin  = (state_q == ST_PUSH) ||
                    ((state_q == ST_MEM) && mem_ack && mode_q.to_mem);
        last_beat = (left_q == BEAT_W'(1));
        step      = {{(ADDR_W-3){1'b0}}, mode_q.inc, 2'b00};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            hold_q  <= '0;
            done_q  <= '0;
            err_q   <= '0;
        end else begin
            done_q <= '0;
            err_q  <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (start && en) begin
                        mode_q <= mode;
                        addr_q <= base;
                        left_q <= beats;
                        if (misaligned)
                            err_q[mode.to_mem] <= 1'b1;
                        else if (beats == '0)
                            done_q[mode.to_mem] <= 1'b1;
                        else
                            state_q <= mode.to_mem ? ST_PULL : ST_MEM;
                    end
                end
                ST_PULL: begin
                    hold_q  <= buf_rdata;
                    state_q <= ST_MEM;
                end
                ST_MEM: begin
                    if (mem_ack && !mode_q.to_mem) begin
                        hold_q  <= mem_rdata;
                        state_q <= ST_PUSH;
                    end
                end
                default: ;
            endcase
            if (beat_fin) begin
                addr_q <= addr_q + step;
                left_q <= left_q - BEAT_W'(1);
                if (last_beat) begin
                    done_q[mode_q.to_mem] <= 1'b1;
                    state_q <= ST_IDLE;
                end else begin
                    state_q <= mode_q.to_mem ? ST_PULL : ST_MEM;
                end
            end
            if ((state_q != ST_IDLE) && abort[mode_q.to_mem]) begin
                state_q <= ST_IDLE;
                done_q  <= '0;
            end
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done_ev   = done_q;
    assign err_ev    = err_q;
    assign mem_req   = (state_q == ST_MEM);
    assign mem_we    = mode_q.to_mem;
    assign mem_addr  = addr_q;
    assign mem_wdata = hold_q;
    assign buf_rd    = (state_q == ST_PULL);
    assign buf_wr    = (state_q == ST_PUSH);
    assign buf_wdata = hold_q;
endmodule

// File: rtl/sdma_top.sv
module sdma_top
    import sdma_pkg::*;
#(
    parameter int SIZE_W      = 12,
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 64,
    parameter int ALIGN_BYTES = 16,
    localparam int BEAT_W     = SIZE_W + CNT_W - 2,
    localparam int ALIGN_B    = $clog2(ALIGN_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en_i,
    input  logic [SIZE_W-1:0] blk_size_i,
    input  logic [CNT_W-1:0]  blk_cnt_i,
    input  logic              reg_wr_i,
    input  logic [5:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              buf_rd_o,
    input  logic [31:0]       buf_rdata_i,
    output logic              buf_wr_o,
    output logic [31:0]       buf_wdata_o,
    output logic              irq_o
);
    xfer_mode_t        mode;
    logic [ADDR_W-1:0] base;
    logic              start_p;
    logic [1:0]        chan_rst;
    logic              eng_busy;
    logic [1:0]        done_ev, err_ev;
    logic [BEAT_W-1:0] beats;
    logic              misaligned;

    sdma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr_i),
        .reg_addr  (reg_addr_i),
        .reg_wdata (reg_wdata_i),
        .reg_rdata (reg_rdata_o),
        .busy      (eng_busy),
        .done_ev   (done_ev),
        .err_ev    (err_ev),
        .mode      (mode),
        .base_addr (base),
        .start     (start_p),
        .chan_rst  (chan_rst),
        .irq       (irq_o)
    );

    sdma_len #(.SIZE_W(SIZE_W), .CNT_W(CNT_W), .ALIGN_BYTES(ALIGN_BYTES)) u_len (
        .blk_size   (blk_size_i),
        .blk_cnt    (blk_cnt_i),
        .base_low   (base[ALIGN_B-1:0]),
        .beats      (beats),
        .misaligned (misaligned)
    );

    sdma_engine #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .en         (dma_en_i),
        .start      (start_p),
        .mode       (mode),
        .base       (base),
        .beats      (beats),
        .misaligned (misaligned),
        .abort      (chan_rst),
        .busy       (eng_busy),
        .done_ev    (done_ev),
        .err_ev     (err_ev),
        .mem_req    (mem_req_o),
        .mem_we     (mem_we_o),
        .mem_addr   (mem_addr_o),
        .mem_wdata  (mem_wdata_o),
        .mem_rdata  (mem_rdata_i),
        .mem_ack    (mem_ack_i),
        .buf_rd     (buf_rd_o),
        .buf_rdata  (buf_rdata_i),
        .buf_wr     (buf_wr_o),
        .buf_wdata  (buf_wdata_o)
    );
endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              buf_rd,
    input logic              buf_wr,
    input logic              busy,
    input logic [1:0]        done_ev,
    input logic [1:0]        err_ev,
    input logic              start,
    input logic              en,
    input logic              reg_wr,
    input logic              irq
);
    // R2: a pending beat keeps its address and direction until acknowledged
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: buffer is never popped and pushed in the same cycle
    assert_buf_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(buf_rd && buf_wr));

    // R7: completion names one direction and the engine is idle then
    assert_done_one_R7: assert property (@(posedge clk) disable iff (rst)
        (|done_ev) |-> ($onehot0(done_ev) && !busy && !mem_req));

    // R8: an alignment fault leaves the memory port silent
    assert_err_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (|err_ev) |-> (!busy && !mem_req));

    // R9: starts are refused while the enable is low
    assert_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !en && !busy) |=> !busy);

    // R11: the interrupt only rises after a status event or a register write
    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past((|done_ev) || (|err_ev) || reg_wr));
endmodule

bind sdma_top sdma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_req  (mem_req_o),
    .mem_ack  (mem_ack_i),
    .mem_we   (mem_we_o),
    .mem_addr (mem_addr_o),
    .buf_rd   (buf_rd_o),
    .buf_wr   (buf_wr_o),
    .busy     (eng_busy),
    .done_ev  (done_ev),
    .err_ev   (err_ev),
    .start    (start_p),
    .en       (dma_en_i),
    .reg_wr   (reg_wr_i),
    .irq      (irq_o)
);

// File: tb/tb_sdma_top.sv
module tb_sdma_top;
    localparam logic [5:0] A_MODE = 6'h00, A_CTRL = 6'h04, A_CHRST = 6'h08,
                           A_DONE = 6'h0C, A_ERR = 6'h14, A_EMSK = 6'h18,
                           A_ALO = 6'h1C, A_AHI = 6'h20;

    typedef struct packed {
        logic        dir;
        logic        inc;
        logic [11:0] size;
        logic [15:0] cnt;
        logic [31:0] addr;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{1'b1, 1'b1, 12'd16, 16'd2, 32'h40},
        '{1'b0, 1'b1, 12'd8,  16'd3, 32'h100},
        '{1'b1, 1'b0, 12'd4,  16'd3, 32'h80},
        '{1'b0, 1'b0, 12'd12, 16'd1, 32'h10},
        '{1'b1, 1'b1, 12'd0,  16'd5, 32'h20}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dma_en = 1'b0;
    logic [11:0] blk_size = '0;
    logic [15:0] blk_cnt = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        buf_rd, buf_wr;
    logic [31:0] buf_rdata, buf_wdata;
    logic        irq;
    logic        clr = 1'b0;

    logic [31:0] mem [256];
    logic [31:0] sink [128];
    int          rd_ptr, wr_ptr, req_cnt;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;

    function automatic logic [31:0] init_pat(int i);
        return 32'hC0DE0000 | 32'(i);
    endfunction
    function automatic logic [31:0] src_pat(int i);
        return 32'h5A5A0000 + 32'(i);
    endfunction

    sdma_top dut (
        .clk(clk), .rst(rst), .dma_en_i(dma_en), .blk_size_i(blk_size), .blk_cnt_i(blk_cnt),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .buf_rd_o(buf_rd), .buf_rdata_i(buf_rdata),
        .buf_wr_o(buf_wr), .buf_wdata_o(buf_wdata), .irq_o(irq)
    );

    assign mem_rdata = mem[mem_addr[9:2]];
    assign buf_rdata = src_pat(rd_ptr);

    // memory and buffer models
    always @(posedge clk) begin
        if (clr) begin
            rd_ptr  <= 0;
            wr_ptr  <= 0;
            req_cnt <= 0;
            mem_ack <= 1'b0;
            for (int i = 0; i < 256; i++) mem[i] <= init_pat(i);
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack) begin
                req_cnt <= req_cnt + 1;
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            end
            if (buf_rd) rd_ptr <= rd_ptr + 1;
            if (buf_wr) begin
                sink[wr_ptr[6:0]] <= buf_wdata;
                wr_ptr <= wr_ptr + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic wait_done(output logic [31:0] d);
        d = '0;
        for (int k = 0; k < 4000 && d == '0; k++) rd_reg(A_DONE, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=expired exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d, e;
        vec_t t;
        int beats, base_w, snap;
        bit ok;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        pulse_clr();

        // R1: reset state
        rd_reg(A_DONE, d); check(d == 0, "R1 done after reset", d, 0);
        rd_reg(A_ERR, d);  check(d == 0, "R1 err after reset", d, 0);
        rd_reg(A_CTRL, d); check(d == 0, "R1 ctrl after reset", d, 0);
        rd_reg(A_EMSK, d); check(d == 0, "R1 mask after reset", d, 0);
        check(!irq && !mem_req && !buf_rd && !buf_wr, "R1 outputs idle",
              {irq, mem_req, buf_rd, buf_wr}, 0);

        // table of transfers
        dma_en = 1'b1;
        for (int v = 0; v < 5; v++) begin
            t = VEC[v];
            beats  = (int'(t.size) * int'(t.cnt)) / 4;
            base_w = int'(t.addr) / 4;
            pulse_clr();
            blk_size = t.size; blk_cnt = t.cnt;
            wr_reg(A_ALO, t.addr);
            wr_reg(A_AHI, 32'h0);
            wr_reg(A_MODE, (32'(t.dir) << 16) | 32'(t.inc));
            wr_reg(A_CTRL, 32'h1);
            if (beats > 0) begin
                rd_reg(A_CTRL, d); check(d[0] == 1'b1, "R6 busy while running", d, 1);
            end
            wait_done(d);
            e = t.dir ? 32'h0010_0000 : 32'h0001_0000;
            check(d == e, "R7 completion bit", d, e);
            rd_reg(A_CTRL, d); check(d == 0, "R6 start self-cleared", d, 0);
            rd_reg(A_ERR, d);  check(d == 0, "R7 no error", d, 0);
            check(req_cnt == beats, "R4 beat count", req_cnt, beats);
            ok = 1'b1;
            if (t.dir && t.inc) begin
                for (int i = 0; i < beats; i++) if (mem[base_w + i] != src_pat(i)) ok = 1'b0;
                check(ok && rd_ptr == beats, "R2 card-to-memory data", rd_ptr, beats);
            end else if (t.dir) begin
                ok = (mem[base_w] == src_pat(beats - 1)) && (mem[base_w + 1] == init_pat(base_w + 1));
                check(ok, "R5 fixed address card-to-memory", mem[base_w], src_pat(beats - 1));
            end else if (t.inc) begin
                for (int i = 0; i < beats; i++) if (sink[i] != init_pat(base_w + i)) ok = 1'b0;
                check(ok && wr_ptr == beats, "R3 memory-to-card data", wr_ptr, beats);
            end else begin
                for (int i = 0; i < beats; i++) if (sink[i] != init_pat(base_w)) ok = 1'b0;
                check(ok && wr_ptr == beats, "R5 fixed address memory-to-card", sink[0], init_pat(base_w));
            end
            wr_reg(A_DONE, 32'h0);
        end

        // R8: misaligned starts
        pulse_clr();
        blk_size = 12'd16; blk_cnt = 16'd1;
        wr_reg(A_ALO, 32'h44);
        wr_reg(A_MODE, 32'h0001_0001);
        wr_reg(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        rd_reg(A_ERR, d);  check(d == 32'h0002_0000, "R8 misaligned card-to-memory error", d, 32'h20000);
        rd_reg(A_DONE, d); check(d == 0, "R8 no completion", d, 0);
        check(req_cnt == 0, "R8 no request", req_cnt, 0);
        wr_reg(A_ALO, 32'h108);
        wr_reg(A_MODE, 32'h0000_0001);
        wr_reg(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        rd_reg(A_ERR, d);  check(d == 32'h0003_0000, "R8 misaligned memory-to-card error", d, 32'h30000);

        // R11: interrupt and masks
        check(irq == 1'b1, "R11 irq with unmasked error", irq, 1);
        wr_reg(A_EMSK, 32'h0003_0000);
        @(negedge clk); check(irq == 1'b0, "R11 irq masked", irq, 0);
        wr_reg(A_EMSK, 32'h0001_0000);
        @(negedge clk); check(irq == 1'b1, "R11 irq partly masked", irq, 1);

        // R10: write-zero clears
        wr_reg(A_ERR, 32'h0002_0000);
        rd_reg(A_ERR, d); check(d == 32'h0002_0000, "R10 selective clear", d, 32'h20000);
        wr_reg(A_ERR, 32'h0);
        wr_reg(A_EMSK, 32'h0);
        rd_reg(A_ERR, d); check(d == 0 && !irq, "R10 full clear", d, 0);

        // R9: enable low ignores start
        pulse_clr();
        dma_en = 1'b0;
        wr_reg(A_ALO, 32'h40);
        wr_reg(A_MODE, 32'h0001_0001);
        wr_reg(A_CTRL, 32'h1);
        rd_reg(A_CTRL, d); check(d == 0, "R9 not busy when disabled", d, 0);
        repeat (10) @(negedge clk);
        rd_reg(A_DONE, d); check(d == 0 && req_cnt == 0, "R9 no transfer when disabled", req_cnt, 0);
        rd_reg(A_ERR, d);  check(d == 0, "R9 no error when disabled", d, 0);
        dma_en = 1'b1;

        // R12: channel reset
        pulse_clr();
        blk_size = 12'd16; blk_cnt = 16'd1;
        wr_reg(A_ALO, 32'h104);
        wr_reg(A_MODE, 32'h0000_0001);
        wr_reg(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        blk_size = 12'd256;
        wr_reg(A_ALO, 32'h200);
        wr_reg(A_MODE, 32'h0001_0001);
        wr_reg(A_CTRL, 32'h1);
        repeat (10) @(negedge clk);
        wr_reg(A_CHRST, 32'h0000_0200);
        repeat (2) @(negedge clk);
        rd_reg(A_CTRL, d); check(d == 0, "R12 read channel aborted", d, 0);
        snap = req_cnt;
        repeat (20) @(negedge clk);
        check(req_cnt == snap && snap < 64, "R12 no beats after abort", req_cnt, snap);
        rd_reg(A_DONE, d); check(d == 0, "R12 no completion after abort", d, 0);
        rd_reg(A_ERR, d);  check(d == 32'h0001_0000, "R12 other channel flag kept", d, 32'h10000);
        wr_reg(A_CHRST, 32'h0000_0100);
        rd_reg(A_ERR, d);  check(d == 0, "R12 write channel reset clears", d, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule